// File: doc/BRIEF.md
# SRAM Power-Down Handshake Controller

This controller sequences the SRAM banks that sit inside one switchable power domain. On an enable request it releases every bank's power-down control. It then polls the banks' acknowledge lines until they report that the banks are powered. On a disable request it does the reverse and waits for every acknowledge to report that the banks are powered down. Each sequence ends with a one-cycle done pulse, or with a one-cycle error pulse if the acknowledges never match within a bounded time.

Some domains also have a two-step SRAM isolation. One control isolates the SRAM clock. A second control, active low, releases the internal isolation. A static capability input says whether this isolation is present. When it is present, isolation is put in place before power-down and lifted after power-up, with a fixed delay between the two controls.

All timing comes from a clock-cycle prescaler. It is set by the clock frequency in MHz, the poll interval, the isolation delay and the overall time limit, all given in microseconds. The acknowledges come from the SRAM macros, outside the block.

Top module: `sram_pdn_ctrl`

## Requirements
- R1: While reset is held, `pdn` is all ones, `clk_iso` is 1, `iso_rel_n` is 0, and `done` and `err` are 0.
- R2: An `en_req` seen in idle clears every `pdn` bit at that clock edge. The acknowledges are sampled every POLL_CYC = CLK_MHZ*POLL_US cycles, the first sample POLL_CYC edges after the request. The first sample where `ack & ACK_MASK` is zero completes the power-up.
- R3: A `dis_req` seen in idle sets every `pdn` bit, one edge after the isolation step when isolation is present. Sampling follows the same interval. The first sample where `ack & ACK_MASK` equals ACK_MASK completes the power-down.
- R4: Acknowledge bits whose ACK_MASK bit is 0 have no effect on when a sequence completes.
- R5: With `iso_cap`=1, enable drives `iso_rel_n` to 1 at the matching sample edge. It clears `clk_iso` DLY_CYC = CLK_MHZ*ISO_US edges later, on the same edge that raises `done`.
- R6: With `iso_cap`=1, disable sets `clk_iso` at the request edge and clears `iso_rel_n` DLY_CYC edges later. It sets `pdn` one edge after that. `clk_iso` is always 1 while any `pdn` bit is 1.
- R7: If LIMIT = TIMEOUT_US/POLL_US samples in a row fail, `err` pulses for one cycle on the edge of the last sample. The controller returns to idle, and `pdn`, `clk_iso` and `iso_rel_n` keep their last values.
- R8: A request that arrives while a sequence is running is ignored. It changes no output and is not remembered after done.
- R9: When `en_req` and `dis_req` are both high in idle, the enable sequence runs.
- R10: `done` and `err` are single-cycle pulses and are never high together.
- R11: With `iso_cap`=0, `clk_iso` and `iso_rel_n` keep their values through both sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_req | input | 1 | Request to power up the SRAM banks |
| dis_req | input | 1 | Request to power down the SRAM banks |
| iso_cap | input | 1 | Static: SRAM isolation controls are present |
| ack | input | N_BANKS | Power-down acknowledge from the SRAM macros |
| pdn | output | N_BANKS | SRAM power-down controls, 1 = powered down |
| clk_iso | output | 1 | SRAM clock isolation, 1 = isolated |
| iso_rel_n | output | 1 | SRAM internal isolation release, active low |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | One-cycle pulse when a sequence times out |

## Verification
The bench measures the cycle on which done or err appears for each sequence. A controller that samples the acknowledges at the wrong rate, or that skips the isolation delay, lands on a different cycle. Masked-out acknowledge bits are set against the expected direction. A controller that compares the unmasked value would then never finish and would report a timeout instead. Timeouts in both directions check that the outputs stay where they were, which catches a design that restores its reset state after an error. Requests made in the middle of a sequence, and both requests at once, catch a design that queues requests or gives the wrong one priority. The intermediate edges of the isolation steps are checked cycle by cycle, so a reversed order of the two isolation controls shows up.

// File: rtl/sram_pdn_pkg.sv
package sram_pdn_pkg;

    localparam int MAX_BANKS = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EN_POLL,
        S_EN_ISO,
        S_DIS_ISO,
        S_DIS_SET,
        S_DIS_POLL
    } seq_state_e;

    // want_set=1: every masked bit must be 1; want_set=0: every masked bit must be 0
    function automatic logic ack_ok(input logic [MAX_BANKS-1:0] ack_v,
                                    input logic [MAX_BANKS-1:0] mask_v,
                                    input logic want_set);
        if (want_set)
            return (ack_v & mask_v) == mask_v;
        else
            return (ack_v & mask_v) == '0;
    endfunction

    function automatic int us_to_cyc(input int mhz, input int us);
        return mhz * us;
    endfunction

endpackage

// File: rtl/sram_pdn_timer.sv
module sram_pdn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/sram_pdn_fsm.sv
module sram_pdn_fsm
    import sram_pdn_pkg::*;
#(
    parameter int                   N_BANKS  = 4,
    parameter logic [N_BANKS-1:0]   ACK_MASK = '1,
    parameter int                   POLL_CYC = 1000,
    parameter int                   DLY_CYC  = 100,
    parameter int                   LIMIT    = 100000,
    parameter int                   TW       = 10,
    parameter int                   PW       = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_req,
    input  logic               dis_req,
    input  logic               iso_cap,
    input  logic [N_BANKS-1:0] ack,
    input  logic               tmr_exp,
    output logic               tmr_load,
    output logic [TW-1:0]      tmr_val,
    output logic [N_BANKS-1:0] pdn,
    output logic               clk_iso,
    output logic               iso_rel_n,
    output logic               done,
    output logic               err
);
    typedef struct packed {
        logic [N_BANKS-1:0] pdn;
        logic               clk_iso;
        logic               iso_rel_n;
    } drv_t;

    localparam drv_t DRV_RST = '{pdn: '1, clk_iso: 1'b1, iso_rel_n: 1'b0};

    seq_state_e st, st_n;
    drv_t       drv, drv_n;
    logic [PW-1:0] polls, polls_n;
    logic       done_n, err_n;
    logic       hit_clr, hit_set;

    assign hit_clr = ack_ok(MAX_BANKS'(ack), MAX_BANKS'(ACK_MASK), 1'b0);
    assign hit_set = ack_ok(MAX_BANKS'(ack), MAX_BANKS'(ACK_MASK), 1'b1);

    always_comb begin
        st_n     = st;
        drv_n    = drv;
        polls_n  = polls;
        done_n   = 1'b0;
        err_n    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_IDLE: begin
                if (en_req) begin
                    drv_n.pdn = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(POLL_CYC - 1);
                    polls_n   = '0;
                    st_n      = S_EN_POLL;
                end else if (dis_req) begin
                    if (iso_cap) begin
                        drv_n.clk_iso = 1'b1;
                        tmr_load      = 1'b1;
                        tmr_val       = TW'(DLY_CYC - 1);
                        st_n          = S_DIS_ISO;
                    end else begin
                        drv_n.pdn = '1;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(POLL_CYC - 1);
                        polls_n   = '0;
                        st_n      = S_DIS_POLL;
                    end
                end
            end
            S_EN_POLL, S_DIS_POLL: begin
                if (tmr_exp) begin
                    if ((st == S_EN_POLL) ? hit_clr : hit_set) begin
                        if (st == S_EN_POLL && iso_cap) begin
                            drv_n.iso_rel_n = 1'b1;
                            tmr_load        = 1'b1;
                            tmr_val         = TW'(DLY_CYC - 1);
                            st_n            = S_EN_ISO;
                        end else begin
                            done_n = 1'b1;
                            st_n   = S_IDLE;
                        end
                    end else if (polls == PW'(LIMIT - 1)) begin
                        err_n = 1'b1;
                        st_n  = S_IDLE;
                    end else begin
                        polls_n  = polls + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(POLL_CYC - 1);
                    end
                end
            end
            S_EN_ISO: begin
                if (tmr_exp) begin
                    drv_n.clk_iso = 1'b0;
                    done_n        = 1'b1;
                    st_n          = S_IDLE;
                end
            end
            S_DIS_ISO: begin
                if (tmr_exp) begin
                    drv_n.iso_rel_n = 1'b0;
                    st_n            = S_DIS_SET;
                end
            end
            S_DIS_SET: begin
                drv_n.pdn = '1;
                tmr_load  = 1'b1;
                tmr_val   = TW'(POLL_CYC - 1);
                polls_n   = '0;
                st_n      = S_DIS_POLL;
            end
            default: st_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            drv   <= DRV_RST;
            polls <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            st    <= st_n;
            drv   <= drv_n;
            polls <= polls_n;
            done  <= done_n;
            err   <= err_n;
        end
    end

    assign pdn       = drv.pdn;
    assign clk_iso   = drv.clk_iso;
    assign iso_rel_n = drv.iso_rel_n;
endmodule

// File: rtl/sram_pdn_ctrl.sv
module sram_pdn_ctrl
    import sram_pdn_pkg::*;
#(
    parameter int                 N_BANKS    = 4,
    parameter logic [N_BANKS-1:0] ACK_MASK   = '1,
    parameter int                 CLK_MHZ    = 100,
    parameter int                 POLL_US    = 10,
    parameter int                 ISO_US     = 1,
    parameter int                 TIMEOUT_US = 1000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_req,
    input  logic               dis_req,
    input  logic               iso_cap,
    input  logic [N_BANKS-1:0] ack,
    output logic [N_BANKS-1:0] pdn,
    output logic               clk_iso,
    output logic               iso_rel_n,
    output logic               done,
    output logic               err
);
    localparam int POLL_CYC = us_to_cyc(CLK_MHZ, POLL_US);
    localparam int DLY_CYC  = us_to_cyc(CLK_MHZ, ISO_US);
    localparam int LIMIT    = (TIMEOUT_US / POLL_US < 1) ? 1 : TIMEOUT_US / POLL_US;
    localparam int MAX_CYC  = (POLL_CYC > DLY_CYC) ? POLL_CYC : DLY_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam int PW       = $clog2(LIMIT + 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;

    sram_pdn_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sram_pdn_fsm #(
        .N_BANKS  (N_BANKS),
        .ACK_MASK (ACK_MASK),
        .POLL_CYC (POLL_CYC),
        .DLY_CYC  (DLY_CYC),
        .LIMIT    (LIMIT),
        .TW       (TW),
        .PW       (PW)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en_req    (en_req),
        .dis_req   (dis_req),
        .iso_cap   (iso_cap),
        .ack       (ack),
        .tmr_exp   (tmr_exp),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .pdn       (pdn),
        .clk_iso   (clk_iso),
        .iso_rel_n (iso_rel_n),
        .done      (done),
        .err       (err)
    );
endmodule

// File: rtl/sram_pdn_chk.sv
module sram_pdn_chk #(
    parameter int                 N_BANKS  = 4,
    parameter logic [N_BANKS-1:0] ACK_MASK = '1
) (
    input logic               clk,
    input logic               rst,
    input logic [N_BANKS-1:0] ack,
    input logic [N_BANKS-1:0] pdn,
    input logic               clk_iso,
    input logic               iso_rel_n,
    input logic               done,
    input logic               err
);
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(done && err)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst) err |=> !err); // R7
    AST_ISO_ORDER: assert property (@(posedge clk) disable iff (rst) !clk_iso |-> iso_rel_n); // R5
    AST_PDN_ISOLATED: assert property (@(posedge clk) disable iff (rst) (pdn != '0) |-> clk_iso); // R6
    AST_UP_ACK: assert property (@(posedge clk) disable iff (rst)
        (done && pdn == '0 && clk_iso) |-> $past((ack & ACK_MASK) == '0)); // R2
    AST_DOWN_ACK: assert property (@(posedge clk) disable iff (rst)
        (done && pdn == '1) |-> $past((ack & ACK_MASK) == ACK_MASK)); // R3
endmodule

bind sram_pdn_ctrl sram_pdn_chk #(.N_BANKS(N_BANKS), .ACK_MASK(ACK_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .pdn       (pdn),
    .clk_iso   (clk_iso),
    .iso_rel_n (iso_rel_n),
    .done      (done),
    .err       (err)
);

// File: tb/sram_pdn_ctrl_test.sv
module sram_pdn_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam logic [N-1:0] MASK = 4'b1011;
    // bench timing: POLL_CYC=4, DLY_CYC=2, LIMIT=5 -> timeout after 20 cycles

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_req = 1'b0, dis_req = 1'b0, iso_cap = 1'b0;
    logic [N-1:0] ack = 4'hF;
    logic [N-1:0] pdn;
    logic clk_iso, iso_rel_n, done, err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_pdn_ctrl #(
        .N_BANKS(N), .ACK_MASK(MASK), .CLK_MHZ(2), .POLL_US(2), .ISO_US(1), .TIMEOUT_US(10)
    ) uut (
        .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req), .iso_cap(iso_cap),
        .ack(ack), .pdn(pdn), .clk_iso(clk_iso), .iso_rel_n(iso_rel_n), .done(done), .err(err)
    );

    typedef struct packed {
        logic         op_en;
        logic         cap;
        logic [N-1:0] a;
        logic [7:0]   exp_c;
        logic         exp_err;
        logic [N-1:0] e_pdn;
        logic         e_ci;
        logic         e_rel;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 4'hF, 8'd4,  1'b0, 4'hF, 1'b1, 1'b0}, // R3 down, no isolation
        '{1'b1, 1'b0, 4'h0, 8'd4,  1'b0, 4'h0, 1'b1, 1'b0}, // R2 R11 up, no isolation
        '{1'b0, 1'b0, 4'hF, 8'd4,  1'b0, 4'hF, 1'b1, 1'b0}, // R3 R11
        '{1'b1, 1'b1, 4'h0, 8'd6,  1'b0, 4'h0, 1'b0, 1'b1}, // R5 up with isolation
        '{1'b0, 1'b1, 4'hF, 8'd7,  1'b0, 4'hF, 1'b1, 1'b0}, // R6 down with isolation
        '{1'b1, 1'b1, 4'h4, 8'd6,  1'b0, 4'h0, 1'b0, 1'b1}, // R4 masked bit high
        '{1'b0, 1'b1, 4'hB, 8'd7,  1'b0, 4'hF, 1'b1, 1'b0}, // R4 masked bit low
        '{1'b1, 1'b0, 4'h1, 8'd20, 1'b1, 4'h0, 1'b1, 1'b0}, // R7 up timeout
        '{1'b0, 1'b0, 4'h0, 8'd20, 1'b1, 4'hF, 1'b1, 1'b0}, // R7 down timeout
        '{1'b1, 1'b1, 4'h0, 8'd6,  1'b0, 4'h0, 1'b0, 1'b1}, // R5
        '{1'b1, 1'b1, 4'h0, 8'd6,  1'b0, 4'h0, 1'b0, 1'b1}  // R2 repeat while up
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_seq(input logic e, input logic d, input logic cap, input logic [N-1:0] a,
                           output int c, output logic got_err);
        iso_cap = cap;
        ack     = a;
        en_req  = e;
        dis_req = d;
        @(negedge clk);
        en_req  = 1'b0;
        dis_req = 1'b0;
        c = 0;
        got_err = 1'b0;
        for (int k = 1; k <= 64; k++) begin
            @(negedge clk);
            if (done || err) begin
                c = k;
                got_err = err;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c;
        logic ge;
        repeat (3) @(negedge clk);
        chk("R1 pdn", pdn, 4'hF);
        chk("R1 clk_iso", clk_iso, 1);
        chk("R1 iso_rel_n", iso_rel_n, 0);
        chk("R1 done/err", {done, err}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_seq(VECS[i].op_en, ~VECS[i].op_en, VECS[i].cap, VECS[i].a, c, ge);
            $display("vector %0d (R2/R3/R4/R5/R6/R7/R11)", i);
            chk("vector cycle", c, VECS[i].exp_c);
            chk("vector err", ge, VECS[i].exp_err);
            chk("vector pdn", pdn, VECS[i].e_pdn);
            chk("vector clk_iso", clk_iso, VECS[i].e_ci);
            chk("vector iso_rel_n", iso_rel_n, VECS[i].e_rel);
            @(negedge clk);
            chk("R10 single pulse", {done, err}, 0);
        end

        // R6 intermediate edges of isolated power-down (starting powered up, isolation lifted)
        iso_cap = 1'b1; ack = 4'hF; dis_req = 1'b1;
        @(negedge clk); dis_req = 1'b0;
        chk("R6 c0 clk_iso", clk_iso, 1);
        chk("R6 c0 iso_rel_n", iso_rel_n, 1);
        chk("R6 c0 pdn", pdn, 0);
        @(negedge clk);
        chk("R6 c1 iso_rel_n", iso_rel_n, 1);
        @(negedge clk);
        chk("R6 c2 iso_rel_n", iso_rel_n, 0);
        chk("R6 c2 pdn", pdn, 0);
        @(negedge clk);
        chk("R6 c3 pdn", pdn, 4'hF);
        repeat (4) @(negedge clk);
        chk("R6 c7 done", done, 1);
        @(negedge clk);

        // R9 both requests at once: enable wins
        iso_cap = 1'b0; ack = 4'h0; en_req = 1'b1; dis_req = 1'b1;
        @(negedge clk); en_req = 1'b0; dis_req = 1'b0;
        chk("R9 pdn cleared", pdn, 0);
        repeat (4) @(negedge clk);
        chk("R9 done", done, 1);
        chk("R9 pdn", pdn, 0);
        @(negedge clk);

        // R8 request during a running sequence is ignored
        ack = 4'hF; dis_req = 1'b1;
        @(negedge clk); dis_req = 1'b0;
        @(negedge clk);
        en_req = 1'b1;
        @(negedge clk); en_req = 1'b0;
        chk("R8 pdn mid", pdn, 4'hF);
        repeat (2) @(negedge clk);
        chk("R8 done", done, 1);
        chk("R8 pdn at done", pdn, 4'hF);
        repeat (3) @(negedge clk);
        chk("R8 not remembered", pdn, 4'hF);
        chk("R8 no pulse", {done, err}, 0);

        // R5 intermediate edges of isolated power-up
        iso_cap = 1'b1; ack = 4'h0; en_req = 1'b1;
        @(negedge clk); en_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R5 c4 iso_rel_n", iso_rel_n, 1);
        chk("R5 c4 clk_iso", clk_iso, 1);
        @(negedge clk);
        chk("R5 c5 clk_iso", clk_iso, 1);
        chk("R5 c5 done", done, 0);
        @(negedge clk);
        chk("R5 c6 clk_iso", clk_iso, 0);
        chk("R5 c6 done", done, 1);
        @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule